// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Collision Alert

This block is a true dual-port memory of 36-bit words. The two ports are identical. Each has its own clock, enable, write strobe, byte enables, address and write data. Either port can read or write any word, including a word the other port is using in the same cycle. The word is split into four 9-bit lanes, and each lane has its own enable for both writes and reads. The depth is a parameter.

Every request is registered on the rising edge of its port's clock. A single mode input chooses the read latency for both ports:

- **Flow-through:** the data appears in the cycle right after the address is sampled.
- **Pipelined:** the data comes through one more register, one cycle later.

An output enable clears each port's read data at once, with no clock edge needed.

When one port reads an address that the other port writes in the same cycle, the read data is not guaranteed. The reading port raises a collision flag, aligned with that read data. When both ports write the same word in the same cycle, the word ends up holding one of the two values.

Top module: `dpram_cd`

## Requirements
- R1: Each port samples en, we, ben, addr and wdata on the rising edge of its own clock. A write sampled at one edge is visible to any read, from either port, that is sampled at a later edge.
- R2: The word is 36 bits wide and is made of four 9-bit lanes. Lane l covers bits [9l+8:9l] and is controlled by ben bit l.
- R3: A word written by one port can be read back unchanged by the other port.
- R4: When a port's sampled read and the other port's sampled write hit the same address at the same edge, that port's coll output is 1. The flag appears in the same cycle as the read data for that request: the next cycle in flow-through mode, one cycle later in pipelined mode.
- R5: coll stays 0 for a request that is a write, for a request whose enable is low, and for a read at a different address from the other port's write.
- R6: After both ports write the same address at the same edge with all lanes enabled, each lane of that word holds the value from one of the two writes.
- R7: With pipe_sel=0 (flow-through), read data is valid in the cycle after the address is sampled. For a cycle that is not a read, the output is zero.
- R8: With pipe_sel=1 (pipelined), read data appears one cycle later than in flow-through mode. The output keeps its last read value while the port is not reading.
- R9: A write changes only the lanes whose ben bit is 1. A read returns the enabled lanes and zeros in all other lanes.
- R10: When oe is 0, the port's rdata is zero at once, without a clock edge. When oe returns to 1, the previous value is restored.
- R11: A request with en=0 does not change memory, even when we=1.
- R12: After reset, rdata and coll of both ports are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset of the port registers |
| pipe_sel | input | 1 | 0 = flow-through read, 1 = pipelined read |
| en_a | input | 1 | Port A request enable |
| we_a | input | 1 | Port A write (1) or read (0) |
| ben_a | input | 4 | Port A lane enables |
| addr_a | input | 10 | Port A word address |
| wdata_a | input | 36 | Port A write data |
| oe_a | input | 1 | Port A output enable, asynchronous |
| rdata_a | output | 36 | Port A read data |
| coll_a | output | 1 | Port A collision alert |
| en_b | input | 1 | Port B request enable |
| we_b | input | 1 | Port B write (1) or read (0) |
| ben_b | input | 4 | Port B lane enables |
| addr_b | input | 10 | Port B word address |
| wdata_b | input | 36 | Port B write data |
| oe_b | input | 1 | Port B output enable, asynchronous |
| rdata_b | output | 36 | Port B read data |
| coll_b | output | 1 | Port B collision alert |

## Verification
The collision properties sample the other port's request on the local clock, so they assume both clocks are the same net. The stimulus drives both ports from one clock.

The properties also assume the following about the inputs:
- Addresses stay below the depth.
- pipe_sel changes only while both ports are idle.
- oe is high at the clock edges whenever the pipelined output is checked for holding.

The stimulus keeps to all of these. It changes pipe_sel only after a drain of idle cycles, and it toggles oe only between edges.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   typedef enum logic {
      RD_FLOW = 1'b0,
      RD_PIPE = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/dpr_in_reg.sv
module dpr_in_reg #(
   parameter int unsigned WORD_W = 36,
   parameter int unsigned LANES  = 4,
   parameter int unsigned AW     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [LANES-1:0]  ben,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] wdata,
   output logic              en_q,
   output logic              we_q,
   output logic [LANES-1:0]  ben_q,
   output logic [AW-1:0]     addr_q,
   output logic [WORD_W-1:0] wdata_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         we_q    <= 1'b0;
         ben_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         en_q    <= en;
         we_q    <= we;
         ben_q   <= ben;
         addr_q  <= addr;
         wdata_q <= wdata;
      end
   end
endmodule

// File: rtl/dpr_bank.sv
module dpr_bank #(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned AW     = 10,
   parameter int unsigned WORD_W = 36,
   parameter int unsigned LANES  = 4,
   parameter bit          FLIP   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [LANES-1:0]  wr_ben,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [LANES-1:0]  peer_tag,
   input  logic [AW-1:0]     rd0_addr,
   input  logic [AW-1:0]     rd1_addr,
   output logic [WORD_W-1:0] rd0_data,
   output logic [LANES-1:0]  rd0_tag,
   output logic [WORD_W-1:0] rd1_data,
   output logic [LANES-1:0]  rd1_tag
);
   localparam int unsigned LW = WORD_W / LANES;

   logic [WORD_W-1:0] store [DEPTH];
   logic [LANES-1:0]  tags  [DEPTH];

   // One writer per array: this port's data and its "newest" markers.
   always_ff @(posedge clk) begin
      for (int l = 0; l < int'(LANES); l++) begin
         if (wr_en && wr_ben[l]) begin
            store[wr_addr][l*LW +: LW] <= wr_data[l*LW +: LW];
            tags[wr_addr][l]           <= peer_tag[l] ^ FLIP;
         end
      end
   end

   assign rd0_data = store[rd0_addr];
   assign rd0_tag  = tags[rd0_addr];
   assign rd1_data = store[rd1_addr];
   assign rd1_tag  = tags[rd1_addr];

   AST_WR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < int'(DEPTH))); // R1
endmodule

// File: rtl/dpr_rd_path.sv
module dpr_rd_path
   import dpr_pkg::*;
#(
   parameter int unsigned WORD_W = 36,
   parameter int unsigned LANES  = 4,
   parameter int unsigned AW     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rd_mode_e          mode,
   input  logic              oe,
   input  logic              rd_ok,
   input  logic [LANES-1:0]  ben,
   input  logic [AW-1:0]     own_addr,
   input  logic              peer_wr,
   input  logic [AW-1:0]     peer_addr,
   input  logic [WORD_W-1:0] word_a,
   input  logic [LANES-1:0]  tag_a,
   input  logic [WORD_W-1:0] word_b,
   input  logic [LANES-1:0]  tag_b,
   output logic [WORD_W-1:0] rdata,
   output logic              coll
);
   localparam int unsigned LW = WORD_W / LANES;

   logic [WORD_W-1:0] merged;
   logic [WORD_W-1:0] lane_keep;
   logic [WORD_W-1:0] flow_word;
   logic [WORD_W-1:0] held_word;
   logic              coll_now;
   logic              coll_held;

   // Differing markers mean bank A holds the newer lane.
   for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
      assign merged[l*LW +: LW]    = (tag_a[l] != tag_b[l]) ? word_a[l*LW +: LW]
                                                            : word_b[l*LW +: LW];
      assign lane_keep[l*LW +: LW] = {LW{ben[l]}};
   end
   if (LW * LANES < WORD_W) begin : g_pad
      assign merged[WORD_W-1:LW*LANES]    = '0;
      assign lane_keep[WORD_W-1:LW*LANES] = '0;
   end

   assign flow_word = rd_ok ? (merged & lane_keep) : '0;
   assign coll_now  = rd_ok && peer_wr && (own_addr == peer_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_word <= '0;
         coll_held <= 1'b0;
      end else begin
         if (rd_ok) held_word <= flow_word;
         coll_held <= coll_now;
      end
   end

   always_comb begin
      if (!oe)                 rdata = '0;
      else if (mode == RD_PIPE) rdata = held_word;
      else                     rdata = flow_word;
      coll = (mode == RD_PIPE) ? coll_held : coll_now;
   end
endmodule

// File: rtl/dpram_cd.sv
module dpram_cd
   import dpr_pkg::*;
#(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned WORD_W = 36,
   parameter int unsigned LANES  = 4
) (
   input  logic                              clk_a,
   input  logic                              clk_b,
   input  logic                              rst_n,
   input  logic                              pipe_sel,
   input  logic                              en_a,
   input  logic                              we_a,
   input  logic [LANES-1:0]                  ben_a,
   input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] addr_a,
   input  logic [WORD_W-1:0]                 wdata_a,
   input  logic                              oe_a,
   output logic [WORD_W-1:0]                 rdata_a,
   output logic                              coll_a,
   input  logic                              en_b,
   input  logic                              we_b,
   input  logic [LANES-1:0]                  ben_b,
   input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] addr_b,
   input  logic [WORD_W-1:0]                 wdata_b,
   input  logic                              oe_b,
   output logic [WORD_W-1:0]                 rdata_b,
   output logic                              coll_b
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned LW = WORD_W / LANES;

   initial begin
      AST_PARAM_LANES: assert (LANES >= 1 && (WORD_W % LANES) == 0) else $error("lane split"); // R2
      AST_PARAM_DEPTH: assert (DEPTH >= 2) else $error("depth too small"); // R1
   end

   rd_mode_e mode;
   assign mode = rd_mode_e'(pipe_sel);

   logic              en_qa, we_qa, en_qb, we_qb;
   logic [LANES-1:0]  ben_qa, ben_qb;
   logic [AW-1:0]     addr_qa, addr_qb;
   logic [WORD_W-1:0] wd_qa, wd_qb;

   dpr_in_reg #(.WORD_W(WORD_W), .LANES(LANES), .AW(AW)) u_in_a (
      .clk(clk_a), .rst_n(rst_n), .en(en_a), .we(we_a), .ben(ben_a),
      .addr(addr_a), .wdata(wdata_a), .en_q(en_qa), .we_q(we_qa),
      .ben_q(ben_qa), .addr_q(addr_qa), .wdata_q(wd_qa));

   dpr_in_reg #(.WORD_W(WORD_W), .LANES(LANES), .AW(AW)) u_in_b (
      .clk(clk_b), .rst_n(rst_n), .en(en_b), .we(we_b), .ben(ben_b),
      .addr(addr_b), .wdata(wdata_b), .en_q(en_qb), .we_q(we_qb),
      .ben_q(ben_qb), .addr_q(addr_qb), .wdata_q(wd_qb));

   logic wr_a, wr_b, rd_a, rd_b;
   assign wr_a = en_qa && we_qa;
   assign wr_b = en_qb && we_qb;
   assign rd_a = en_qa && !we_qa;
   assign rd_b = en_qb && !we_qb;

   // Bank X read port 0 follows port A's address, read port 1 port B's.
   logic [WORD_W-1:0] xa_d0, xa_d1, xb_d0, xb_d1;
   logic [LANES-1:0]  xa_t0, xa_t1, xb_t0, xb_t1;

   dpr_bank #(.DEPTH(DEPTH), .AW(AW), .WORD_W(WORD_W), .LANES(LANES), .FLIP(1'b1)) u_bank_a (
      .clk(clk_a), .rst_n(rst_n), .wr_en(wr_a), .wr_addr(addr_qa), .wr_ben(ben_qa),
      .wr_data(wd_qa), .peer_tag(xb_t0), .rd0_addr(addr_qa), .rd1_addr(addr_qb),
      .rd0_data(xa_d0), .rd0_tag(xa_t0), .rd1_data(xa_d1), .rd1_tag(xa_t1));

   dpr_bank #(.DEPTH(DEPTH), .AW(AW), .WORD_W(WORD_W), .LANES(LANES), .FLIP(1'b0)) u_bank_b (
      .clk(clk_b), .rst_n(rst_n), .wr_en(wr_b), .wr_addr(addr_qb), .wr_ben(ben_qb),
      .wr_data(wd_qb), .peer_tag(xa_t1), .rd0_addr(addr_qa), .rd1_addr(addr_qb),
      .rd0_data(xb_d0), .rd0_tag(xb_t0), .rd1_data(xb_d1), .rd1_tag(xb_t1));

   dpr_rd_path #(.WORD_W(WORD_W), .LANES(LANES), .AW(AW)) u_rd_a (
      .clk(clk_a), .rst_n(rst_n), .mode(mode), .oe(oe_a), .rd_ok(rd_a), .ben(ben_qa),
      .own_addr(addr_qa), .peer_wr(wr_b), .peer_addr(addr_qb),
      .word_a(xa_d0), .tag_a(xa_t0), .word_b(xb_d0), .tag_b(xb_t0),
      .rdata(rdata_a), .coll(coll_a));

   dpr_rd_path #(.WORD_W(WORD_W), .LANES(LANES), .AW(AW)) u_rd_b (
      .clk(clk_b), .rst_n(rst_n), .mode(mode), .oe(oe_b), .rd_ok(rd_b), .ben(ben_qb),
      .own_addr(addr_qb), .peer_wr(wr_a), .peer_addr(addr_qa),
      .word_a(xa_d1), .tag_a(xa_t1), .word_b(xb_d1), .tag_b(xb_t1),
      .rdata(rdata_b), .coll(coll_b));

   // Port-level checks; peer signals are sampled on the local clock,
   // which is meaningful when both ports share one clock.
   logic [WORD_W-1:0] in_mask_a;
   for (genvar l = 0; l < int'(LANES); l++) begin : g_imask
      assign in_mask_a[l*LW +: LW] = {LW{ben_a[l]}};
   end
   if (LW * LANES < WORD_W) begin : g_imask_pad
      assign in_mask_a[WORD_W-1:LW*LANES] = '0;
   end

   AST_A_COLL_NEEDS_READ: assert property (@(posedge clk_a) disable iff (!rst_n)
      (!pipe_sel && coll_a) |-> ($past(en_a) && !$past(we_a))); // R5
   AST_B_COLL_NEEDS_READ: assert property (@(posedge clk_b) disable iff (!rst_n)
      (!pipe_sel && coll_b) |-> ($past(en_b) && !$past(we_b))); // R5
   AST_A_COLL_PEER_WRITE: assert property (@(posedge clk_a) disable iff (!rst_n)
      (!pipe_sel && coll_a) |-> ($past(en_b) && $past(we_b) && ($past(addr_b) == $past(addr_a)))); // R4
   AST_A_FLOW_LANES: assert property (@(posedge clk_a) disable iff (!rst_n)
      !pipe_sel |-> ((rdata_a & ~$past(in_mask_a)) == '0)); // R9
   AST_A_PIPE_HOLD: assert property (@(posedge clk_a) disable iff (!rst_n)
      (pipe_sel && $past(pipe_sel) && oe_a && $past(oe_a)
       && !($past(en_a, 2) && !$past(we_a, 2))) |-> $stable(rdata_a)); // R8
endmodule

// File: tb/test_dpram_cd.sv
`timescale 1ns/1ps
module test_dpram_cd;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        pipe_sel;
   logic        en_a, we_a, oe_a, coll_a, en_b, we_b, oe_b, coll_b;
   logic [3:0]  ben_a, ben_b;
   logic [9:0]  addr_a, addr_b;
   logic [35:0] wdata_a, wdata_b, rdata_a, rdata_b;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;   // 125 MHz, posedge at 8k-4, negedge at 8k

   dpram_cd i_dpram_cd (
      .clk_a(clk), .clk_b(clk), .rst_n(rst_n), .pipe_sel(pipe_sel),
      .en_a(en_a), .we_a(we_a), .ben_a(ben_a), .addr_a(addr_a), .wdata_a(wdata_a),
      .oe_a(oe_a), .rdata_a(rdata_a), .coll_a(coll_a),
      .en_b(en_b), .we_b(we_b), .ben_b(ben_b), .addr_b(addr_b), .wdata_b(wdata_b),
      .oe_b(oe_b), .rdata_b(rdata_b), .coll_b(coll_b));

   // scoreboard queues (parallel)
   int          q_due[$];
   int          q_port[$];
   logic [35:0] q_exp[$];
   logic [35:0] q_alt[$];
   bit          q_chk[$];
   bit          q_coll[$];
   string       q_req[$];

   logic [35:0] ref_m [1024];
   logic [35:0] alt_m [1024];
   logic [35:0] last_e [2];
   logic [35:0] last_x [2];
   bit          last_ok [2];

   function automatic logic [35:0] lmask(input logic [3:0] b);
      logic [35:0] m;
      for (int l = 0; l < 4; l++) m[l*9 +: 9] = {9{b[l]}};
      return m;
   endfunction

   function automatic bit lanes_ok(input logic [35:0] act, e, x);
      for (int l = 0; l < 4; l++)
         if (act[l*9 +: 9] !== e[l*9 +: 9] && act[l*9 +: 9] !== x[l*9 +: 9]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check(input bit ok, input string req, input logic [35:0] act, exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // monitor: pops items due at this negedge
   always @(negedge clk) begin
      int idx;
      idx = int'($time / 8);
      while (q_due.size() > 0 && q_due[0] <= idx) begin
         logic [35:0] act;
         logic        ac;
         act = (q_port[0] == 0) ? rdata_a : rdata_b;
         ac  = (q_port[0] == 0) ? coll_a : coll_b;
         if (q_due[0] < idx) check(1'b0, {q_req[0], " missed"}, act, q_exp[0]);
         else begin
            if (q_chk[0]) check(lanes_ok(act, q_exp[0], q_alt[0]), q_req[0], act, q_exp[0]);
            check(ac == q_coll[0], {q_req[0], " coll"}, {35'd0, ac}, {35'd0, q_coll[0]});
         end
         void'(q_due.pop_front()); void'(q_port.pop_front()); void'(q_exp.pop_front());
         void'(q_alt.pop_front()); void'(q_chk.pop_front()); void'(q_coll.pop_front());
         void'(q_req.pop_front());
      end
   end

   task automatic apply_wr(input int ad, input logic [3:0] b, input logic [35:0] d, input bit to_ref, to_alt);
      for (int l = 0; l < 4; l++) if (b[l]) begin
         if (to_ref) ref_m[ad][l*9 +: 9] = d[l*9 +: 9];
         if (to_alt) alt_m[ad][l*9 +: 9] = d[l*9 +: 9];
      end
   endtask

   task automatic step(input bit ea, wa, input logic [3:0] ba, input int aa, input logic [35:0] da,
                       input bit eb, wb, input logic [3:0] bb, input int ab, input logic [35:0] db,
                       input string req);
      int k;
      bit en[2], we[2];
      int ad[2];
      logic [3:0] be[2];
      @(posedge clk); #1;
      en_a = ea; we_a = wa; ben_a = ba; addr_a = aa[9:0]; wdata_a = da;
      en_b = eb; we_b = wb; ben_b = bb; addr_b = ab[9:0]; wdata_b = db;
      k = int'(($time + 4) / 8);
      en[0] = ea; we[0] = wa; ad[0] = aa; be[0] = ba;
      en[1] = eb; we[1] = wb; ad[1] = ab; be[1] = bb;
      for (int p = 0; p < 2; p++) begin
         bit rd, cl;
         logic [35:0] e, x;
         rd = en[p] && !we[p];
         cl = rd && en[1-p] && we[1-p] && ad[p] == ad[1-p];
         e = rd ? (ref_m[ad[p]] & lmask(be[p])) : 36'd0;
         x = rd ? (alt_m[ad[p]] & lmask(be[p])) : 36'd0;
         q_port.push_back(p); q_coll.push_back(cl); q_req.push_back(req);
         if (pipe_sel) begin
            q_due.push_back(k + 2);
            if (rd) begin q_exp.push_back(e); q_alt.push_back(x); q_chk.push_back(!cl); end
            else begin q_exp.push_back(last_e[p]); q_alt.push_back(last_x[p]); q_chk.push_back(last_ok[p]); end
         end else begin
            q_due.push_back(k + 1);
            q_exp.push_back(e); q_alt.push_back(x); q_chk.push_back(!cl);
         end
         if (rd) begin last_e[p] = e; last_x[p] = x; last_ok[p] = !cl; end
      end
      if (ea && wa && eb && wb && aa == ab) begin
         apply_wr(aa, ba, da, 1, 0);
         apply_wr(ab, bb, db, 0, 1);
      end else begin
         if (ea && wa) apply_wr(aa, ba, da, 1, 1);
         if (eb && wb) apply_wr(ab, bb, db, 1, 1);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 4'h0, 0, 36'd0, 0, 0, 4'h0, 0, 36'd0, "R8 idle");
   endtask

   task automatic drain();
      idle(3);
      while (q_due.size() > 0) @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] lf;
      for (int i = 0; i < 1024; i++) begin ref_m[i] = '0; alt_m[i] = '0; end
      for (int p = 0; p < 2; p++) begin last_e[p] = '0; last_x[p] = '0; last_ok[p] = 1'b1; end
      rst_n = 0; pipe_sel = 0; oe_a = 1; oe_b = 1;
      en_a = 0; we_a = 0; ben_a = 0; addr_a = 0; wdata_a = 0;
      en_b = 0; we_b = 0; ben_b = 0; addr_b = 0; wdata_b = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check(rdata_a == 0 && rdata_b == 0, "R12 rdata", rdata_a ^ rdata_b, 36'd0);
      check(!coll_a && !coll_b, "R12 coll", {34'd0, coll_a, coll_b}, 36'd0);

      // flow-through: cross-port write then read (R1, R3, R7)
      step(1, 1, 4'hF, 5, 36'h1_2345_6789, 1, 1, 4'hF, 9, 36'hF_EDCB_A987, "R3 wr");
      step(1, 0, 4'hF, 9, 36'd0, 1, 0, 4'hF, 5, 36'd0, "R3");
      step(1, 0, 4'hF, 5, 36'd0, 0, 0, 4'h0, 0, 36'd0, "R7");
      // lane writes and lane reads (R2, R9)
      step(1, 1, 4'b0101, 5, 36'hA_AAAA_AAAA, 0, 0, 4'h0, 0, 36'd0, "R9 wr");
      step(1, 0, 4'hF, 5, 36'd0, 1, 0, 4'b0010, 5, 36'd0, "R9");
      step(0, 0, 4'h0, 0, 36'd0, 1, 0, 4'b1000, 5, 36'd0, "R2");
      // disabled write ignored (R11)
      step(0, 1, 4'hF, 5, 36'h0_0000_0001, 0, 0, 4'h0, 0, 36'd0, "R11 wr");
      step(1, 0, 4'hF, 5, 36'd0, 0, 0, 4'h0, 0, 36'd0, "R11");
      // collisions (R4) and non-collisions (R5)
      step(1, 1, 4'hF, 20, 36'h3_3333_3333, 1, 1, 4'hF, 21, 36'h4_4444_4444, "R5 wr");
      step(1, 0, 4'hF, 21, 36'd0, 1, 1, 4'hF, 21, 36'h5_5555_5555, "R4 a");
      step(1, 1, 4'hF, 20, 36'h6_6666_6666, 1, 0, 4'hF, 20, 36'd0, "R4 b");
      step(1, 0, 4'hF, 20, 36'd0, 1, 1, 4'hF, 21, 36'h7_7777_7777, "R5 diff");
      step(0, 0, 4'hF, 21, 36'd0, 1, 1, 4'hF, 21, 36'h8_8888_8888, "R5 dis");
      step(1, 1, 4'hF, 21, 36'h9_9999_9999, 1, 1, 4'hF, 20, 36'h1_1111_1111, "R5 ww");
      // same-address dual write (R6)
      step(1, 1, 4'hF, 30, 36'hC_0C0C_0C0C, 1, 1, 4'hF, 30, 36'h3_0303_0303, "R6 wr");
      step(1, 0, 4'hF, 30, 36'd0, 1, 0, 4'hF, 30, 36'd0, "R6");
      drain();

      // pipelined mode (R8, R4)
      pipe_sel = 1;
      step(1, 0, 4'hF, 9, 36'd0, 1, 0, 4'hF, 21, 36'd0, "R8");
      idle(2);
      step(1, 0, 4'b0011, 5, 36'd0, 1, 1, 4'hF, 5, 36'h2_2222_2222, "R4 pipe");
      step(1, 0, 4'hF, 5, 36'd0, 0, 0, 4'h0, 0, 36'd0, "R8 after");
      idle(1);
      drain();

      // output enable acts without a clock edge (R10)
      @(posedge clk); #1 oe_a = 0; #1;
      check(rdata_a == 0, "R10 low", rdata_a, 36'd0);
      oe_a = 1; #1;
      check(rdata_a == last_e[0], "R10 high", rdata_a, last_e[0]);

      // mixed traffic in both modes: A writes 0..15, B writes 16..31
      for (int m = 0; m < 2; m++) begin
         pipe_sel = m[0];
         for (int i = 0; i < 16; i++)
            step(1, 1, 4'hF, i, {4'h1, 32'(i * 32'h01010101)}, 1, 1, 4'hF, i + 16, {4'h2, 32'(i * 32'h10203)}, "R1 init");
         lf = 32'hACE1_0001;
         for (int i = 0; i < 300; i++) begin
            int xa, xb;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            xa = int'(lf[4:0]); xb = int'(lf[12:8]);
            step(lf[16], lf[17] && xa < 16, lf[23:20], xa, {lf[3:0], lf},
                 lf[18], lf[19] && xb >= 16, lf[27:24], xb, {lf[31:28], ~lf}, "R1 mix");
         end
         drain();
      end

      check(q_due.size() == 0, "R1 queue empty", 36'(q_due.size()), 36'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule